// File: doc/BRIEF.md
# Oversampling Serial Receiver with Three-Sample Voting

This block receives asynchronous serial characters on a single line that idles high. An external tick enable marks each sample instant. The receiver runs in one of two rates: 16 samples per bit, or 8 samples per bit for double speed. A falling edge on the synchronized line opens a candidate start bit. Each bit of the frame is then resolved by a majority vote over three samples taken from the middle of the bit. This covers the start bit, every data bit, the parity bit (which is counted as data) and the stop bit.

The number of data-plus-parity bits can be set from 5 to 10. The received word is delivered right-aligned, with the first received bit in bit 0. It comes with a one-cycle strobe and a framing-error flag. Once the stop bit's last voting sample has been taken, the receiver is ready again at once, so a new start bit may follow a stop bit that has been cut short. Baud generation, parity checking and any buffering are left to the blocks around it.

Top module: `uart_vote_rx`

## Requirements
- R1: After a synchronous active-high reset, `rx_valid`, `rx_ferr` and `rx_data` are all 0, and the receiver waits in idle for a falling edge.
- R2: `dbl_mode`=0 selects 16 samples per bit and `dbl_mode`=1 selects 8. The sample position advances only in cycles where `tick` is high.
- R3: Each bit is decided by the majority of three samples. These are samples 8, 9 and 10 of the bit at 16 samples per bit, and samples 4, 5 and 6 at 8 samples per bit. Sample 1 is the first tick that sees the line low. A single disturbed voting sample does not change the bit, while two disturbed voting samples do.
- R4: A high-to-low change seen between two ticks starts a candidate start bit. If the start-bit vote reads 1, the candidate is dropped, no strobe follows, and the receiver returns to idle.
- R5: `char_len` (5 to 10) sets how many bits follow the start bit before the stop bit. Bit k received lands in `rx_data[k]`, and bits at or above `char_len` read 0. `rx_data` changes only with the strobe.
- R6: The stop bit is voted like the other bits. `rx_ferr` is 1 for a character whose voted stop bit is 0, and 0 otherwise.
- R7: `rx_valid` is high for exactly one clock cycle per accepted character. That cycle follows the tick that took the stop bit's last voting sample.
- R8: The receiver accepts a new start bit on the tick right after the stop bit's last voting sample. Back-to-back frames whose stop bit is only 10 samples long (normal speed) or 6 samples long (double speed) are both received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Sample enable, one pulse per sample instant |
| dbl_mode | input | 1 | 1 = 8 samples per bit, 0 = 16 samples per bit |
| char_len | input | LW | Data-plus-parity bit count, 5 to 10 |
| rxd | input | 1 | Serial line, idles high |
| rx_data | output | DW | Received bits, right-aligned, first bit in bit 0 |
| rx_valid | output | 1 | One-cycle strobe for a new character |
| rx_ferr | output | 1 | Stop bit was voted 0 for the current character |

## Verification
A wrong sample position or a wrong vote window shows up within the very next character. Bits come out shifted or inverted, or a disturbance on one voting sample leaks into the data. If the state machine keeps a dropped start bit, an unrequested strobe appears about one frame later. A late return to idle after the stop bit loses the second frame of a back-to-back pair, and this becomes visible at that frame's expected strobe time. Stale bits that are not cleared between characters show up as nonzero bits above `char_len` in the next shorter character.

// File: rtl/uart_vote_rx.sv
module uart_vote_rx #(
  parameter int DW     = 10,
  parameter int LW     = 4,
  parameter int NS_SPB = 16,
  parameter int DS_SPB = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          dbl_mode,
  input  logic [LW-1:0] char_len,
  input  logic          rxd,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  output logic          rx_ferr
);
  localparam int CW = $clog2(NS_SPB + 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  st_t           st;
  logic          sy1, sy2, prev_s;
  logic [CW-1:0] cnt;
  logic          v0, v1;
  logic [LW-1:0] bidx;
  logic [DW-1:0] shreg;

  logic [CW-1:0] spb, vfirst, nxt;
  logic          maj, last_vote;

  assign spb       = dbl_mode ? CW'(DS_SPB) : CW'(NS_SPB);
  assign vfirst    = spb >> 1;
  assign nxt       = (cnt == spb) ? CW'(1) : cnt + CW'(1);
  assign maj       = (v0 & v1) | (v0 & sy2) | (v1 & sy2);
  assign last_vote = (nxt == vfirst + CW'(2));

  always_ff @(posedge clk) begin
    if (rst) begin
      sy1 <= 1'b1;
      sy2 <= 1'b1;
    end else begin
      sy1 <= rxd;
      sy2 <= sy1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      prev_s   <= 1'b1;
      cnt      <= '0;
      v0       <= 1'b1;
      v1       <= 1'b1;
      bidx     <= '0;
      shreg    <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      rx_ferr  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (tick) begin
        prev_s <= sy2;
        if (st == S_IDLE) begin
          if (prev_s && !sy2) begin
            st  <= S_START;
            cnt <= CW'(1);
          end
        end else begin
          cnt <= nxt;
          if (nxt == vfirst)          v0 <= sy2;
          if (nxt == vfirst + CW'(1)) v1 <= sy2;
          if (last_vote) begin
            case (st)
              S_START: begin
                if (maj) st <= S_IDLE;
                else begin
                  st    <= S_DATA;
                  bidx  <= '0;
                  shreg <= '0;
                end
              end
              S_DATA: begin
                shreg <= shreg | (DW'(maj) << bidx);
                if (bidx == char_len - LW'(1)) st <= S_STOP;
                else bidx <= bidx + LW'(1);
              end
              default: begin
                rx_valid <= 1'b1;
                rx_data  <= shreg;
                rx_ferr  <= ~maj;
                st       <= S_IDLE;
              end
            endcase
          end
        end
      end
    end
  end
endmodule

module uart_vote_rx_chk #(
  parameter int DW = 10,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          dbl_mode,
  input logic          rx_valid,
  input logic [DW-1:0] rx_data,
  input logic [CW-1:0] cnt
);
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid); // R7
  AST_VALID_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(tick)); // R7
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt)); // R2
  AST_REARM_POINT: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (cnt == (dbl_mode ? CW'(6) : CW'(10)))); // R8
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> $stable(rx_data)); // R5
endmodule

bind uart_vote_rx uart_vote_rx_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .dbl_mode(dbl_mode),
  .rx_valid(rx_valid), .rx_data(rx_data), .cnt(cnt)
);

// File: tb/test_uart_vote_rx.sv
module test_uart_vote_rx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       dbl_mode = 1'b0;
  logic [3:0] char_len = 4'd8;
  logic       rxd = 1'b1;
  logic [9:0] rx_data;
  logic       rx_valid, rx_ferr;

  int n_tests = 0, n_fail = 0, nrx = 0, exp_n = 0;
  logic [9:0] got_d [0:255];
  logic       got_f [0:255];

  uart_vote_rx i_uart_vote_rx (
    .clk(clk), .rst(rst), .tick(tick), .dbl_mode(dbl_mode),
    .char_len(char_len), .rxd(rxd),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ferr(rx_ferr)
  );

  always #10 clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      tick = ~tick;
    end
  end

  always @(negedge clk) begin
    if (!rst && rx_valid) begin
      if (nrx < 256) begin
        got_d[nrx] = rx_data;
        got_f[nrx] = rx_ferr;
      end
      nrx = nrx + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic smp(input logic v);
    rxd = v;
    repeat (2) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) smp(1'b1);
  endtask

  task automatic send_frame(input int len, input logic [9:0] d, input logic stopv,
                            input int stop_n, input int cbit, input int cn);
    int s, f;
    logic v;
    s = dbl_mode ? 8 : 16;
    f = s / 2;
    for (int k = 1; k <= s; k++) smp(1'b0);
    for (int b = 0; b < len; b++)
      for (int k = 1; k <= s; k++) begin
        v = d[b];
        if (b == cbit && ((cn >= 1 && k == f) || (cn >= 2 && k == f + 1))) v = ~v;
        smp(v);
      end
    for (int k = 1; k <= stop_n; k++) smp(stopv);
  endtask

  task automatic expect_char(input logic [9:0] d, input logic fe, input string req);
    check(nrx == exp_n + 1, req, nrx, exp_n + 1);
    if (nrx > exp_n) begin
      check(got_d[exp_n] == d, req, got_d[exp_n], d);
      check(got_f[exp_n] == fe, req, got_f[exp_n], fe);
    end
    exp_n = nrx;
  endtask

  function automatic logic [9:0] lmask(input int len);
    return 10'((1 << len) - 1);
  endfunction

  initial begin
    logic [9:0] pats [4];
    int s;
    pats[0] = 10'h3FF; pats[1] = 10'h000; pats[2] = 10'h2AA; pats[3] = 10'h155;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rx_valid == 1'b0, "R1", rx_valid, 0);
    check(rx_ferr == 1'b0, "R1", rx_ferr, 0);
    check(rx_data == 10'h0, "R1", rx_data, 0);
    idle(3);

    for (int m = 0; m < 2; m++) begin
      dbl_mode = m[0];
      s = m ? 8 : 16;
      for (int len = 5; len <= 10; len++) begin
        char_len = 4'(len);
        for (int p = 0; p < 4; p++) begin
          send_frame(len, pats[p], 1'b1, s, -1, 0);
          idle(3);
          expect_char(pats[p] & lmask(len), 1'b0, "R5_R2");
        end
        send_frame(len, 10'h3C5 ^ 10'(len), 1'b1, s, -1, 0);
        idle(3);
        expect_char((10'h3C5 ^ 10'(len)) & lmask(len), 1'b0, "R5");
      end

      char_len = 4'd8;
      send_frame(8, 10'h0A5, 1'b0, s, -1, 0);
      idle(3);
      expect_char(10'h0A5, 1'b1, "R6");
      send_frame(8, 10'h05A, 1'b1, s, -1, 0);
      idle(3);
      expect_char(10'h05A, 1'b0, "R6");

      send_frame(8, 10'h0F0, 1'b1, s, 2, 1);
      idle(3);
      expect_char(10'h0F0, 1'b0, "R3");
      send_frame(8, 10'h0F0, 1'b1, s, 5, 2);
      idle(3);
      expect_char(10'h0D0, 1'b0, "R3");

      for (int k = 1; k <= s / 2; k++) smp(1'b0);
      idle(s * 12);
      check(nrx == exp_n, "R4", nrx, exp_n);
      exp_n = nrx;
      send_frame(8, 10'h03C, 1'b1, s, -1, 0);
      idle(3);
      expect_char(10'h03C, 1'b0, "R4");

      send_frame(8, 10'h0C3, 1'b1, s / 2 + 2, -1, 0);
      send_frame(8, 10'h081, 1'b1, s, -1, 0);
      idle(3);
      check(nrx == exp_n + 2, "R8", nrx, exp_n + 2);
      if (nrx >= exp_n + 2) begin
        check(got_d[exp_n] == 10'h0C3, "R8", got_d[exp_n], 10'h0C3);
        check(got_d[exp_n + 1] == 10'h081, "R8", got_d[exp_n + 1], 10'h081);
        check(got_f[exp_n + 1] == 1'b0, "R8", got_f[exp_n + 1], 0);
      end
      exp_n = nrx;
    end

    dbl_mode = 1'b0;
    char_len = 4'd8;
    send_frame(8, 10'h0FF, 1'b1, 16, -1, 0);
    @(negedge clk);
    check(nrx == exp_n + 1, "R7", nrx, exp_n + 1);
    idle(3);
    check(nrx == exp_n + 1, "R7", nrx, exp_n + 1);
    exp_n = nrx;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule